// File: doc/BRIEF.md
# LIN Break and Sync-Field Tracker

This block monitors an asynchronous serial receive line using the local system clock. It looks for a long dominant-low break, then a recessive delimiter, and then follows the alternating sync character. A downstream oscillator-trim step needs per-cycle timing from this block. For each synchronisation cycle (falling edge to the next falling edge), the block flags the falling edge and the rising edge. At the rising edge it also reports how many clock periods the line stayed low. The high half of each cycle is left free, so the downstream step can compute while the line is high.

The sync character is 0x55. It is sent least-significant bit first with a start bit and a stop bit, so the line carries 0101010101 and one character gives five low pulses. An optional mode accepts two such characters back to back, which gives ten cycles. If the timing is out of bounds, the block drops back to break hunting. A low run that ends tracking still counts toward a new break, so a master that reissues a break partway through a header is still recognised.

Top module: `lin_sync_tracker`

## Requirements
- R1: While reset is held and immediately after it, every output is zero, including `low_count` and `cycle_idx`.
- R2: While hunting, `break_det` pulses for one cycle after the line has been low for exactly 13 × `bit_time` clock periods. A shorter low gives no pulse. A line that stays low forever gives exactly one pulse.
- R3: After a break, a high delimiter of at least `bit_time` clock periods arms tracking. If the line falls earlier than that, the block returns to hunting and emits no `sync_fall`.
- R4: Each synchronisation cycle produces one `sync_fall` pulse and one `sync_rise` pulse, never both in the same cycle. A pin edge first sampled at clock edge k appears on these outputs after edge k+2, that is, 3 clock periods after the pin change.
- R5: `meas_valid` pulses together with `sync_rise`. At that moment `low_count` equals the number of clock edges at which the pin was low during that cycle. `low_count` is one bit wider than `bit_time`, so every accepted value from 1 to 2 × `bit_time` fits.
- R6: `cycle_idx` holds the zero-based index of the current cycle. It is loaded at each `sync_fall` and is stable through the matching `meas_valid`.
- R7: With `dual_sync` at 0, the fifth rise carries `sync_done` in the same cycle, with `cycle_idx` = 4. The block then hunts again.
- R8: With `dual_sync` at 1 when tracking starts, ten cycles are measured, with indices 0 to 9, and `sync_done` comes with the tenth rise.
- R9: A low lasting more than 2 × `bit_time` during tracking ends tracking with no `sync_rise`. Those low periods count toward a new break, so a total low of 13 × `bit_time` gives a fresh `break_det`.
- R10: A high lasting more than 2 × `bit_time` between cycles ends tracking. A high of exactly 2 × `bit_time` does not.
- R11: While `enable` is 0, the block hunts and emits no pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Run the detector; 0 forces hunting |
| dual_sync | input | 1 | 1: expect two sync characters (ten cycles) |
| bit_time | input | CNT_W | Nominal bit time in clock periods (at least 2) |
| rx_in | input | 1 | Asynchronous serial receive line |
| break_det | output | 1 | One-cycle pulse on a detected break |
| sync_fall | output | 1 | One-cycle pulse at the start of each sync cycle |
| sync_rise | output | 1 | One-cycle pulse at the rising edge of each sync cycle |
| meas_valid | output | 1 | `low_count` is valid this cycle |
| low_count | output | CNT_W+1 | Low-period length of the last cycle in clock periods |
| cycle_idx | output | 4 | Index of the current sync cycle |
| sync_done | output | 1 | Last cycle of the sync field measured |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is the closing measurement and the end-of-sync flag. The bench runs complete headers in both modes and counts how often `sync_done` and `meas_valid` coincide, expecting exactly one such cycle per header. The second pair is the low-time abort and the start of break counting. The bench drives a low that overruns the limit, then stretches it to one clock short of the break length and, in a second run, to exactly the break length. It expects no second break in the first run and one in the second, which shows that the low periods before the abort were carried into the break count.

// File: rtl/lin_sync_tracker.sv
module lin_sync_tracker #(
  parameter int CNT_W      = 10,
  parameter int BREAK_BITS = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             dual_sync,
  input  logic [CNT_W-1:0] bit_time,
  input  logic             rx_in,
  output logic             break_det,
  output logic             sync_fall,
  output logic             sync_rise,
  output logic             meas_valid,
  output logic [CNT_W:0]   low_count,
  output logic [3:0]       cycle_idx,
  output logic             sync_done
);

  localparam int RUN_W = CNT_W + $clog2(BREAK_BITS + 1);
  localparam int LEN_W = CNT_W + 1;

  typedef enum logic [2:0] {HUNT, BRK, DELIM, TLOW, THIGH} st_t;

  st_t              st;
  logic             rx_s1, rx_s2;
  logic [RUN_W-1:0] run;
  logic [CNT_W-1:0] hcnt;
  logic [LEN_W-1:0] cnt;
  logic [3:0]       idx;
  logic             dual_q;

  wire              low    = !rx_s2;
  wire [RUN_W-1:0]  thresh = RUN_W'(BREAK_BITS) * RUN_W'(bit_time);
  wire [LEN_W-1:0]  lim    = {bit_time, 1'b0};
  wire [3:0]        last   = dual_q ? 4'd9 : 4'd4;

  assign meas_valid = sync_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_s1     <= 1'b1;
      rx_s2     <= 1'b1;
      st        <= HUNT;
      run       <= '0;
      hcnt      <= '0;
      cnt       <= '0;
      idx       <= '0;
      dual_q    <= 1'b0;
      break_det <= 1'b0;
      sync_fall <= 1'b0;
      sync_rise <= 1'b0;
      sync_done <= 1'b0;
      low_count <= '0;
      cycle_idx <= '0;
    end else begin
      rx_s1     <= rx_in;
      rx_s2     <= rx_s1;
      break_det <= 1'b0;
      sync_fall <= 1'b0;
      sync_rise <= 1'b0;
      sync_done <= 1'b0;
      if (!enable) begin
        st  <= HUNT;
        run <= '0;
        idx <= '0;
      end else begin
        case (st)
          HUNT: begin
            if (low) begin
              if (run != thresh) run <= run + 1'b1;
              if (run == thresh - RUN_W'(1)) begin
                break_det <= 1'b1;
                st        <= BRK;
              end
            end else begin
              run <= '0;
            end
          end
          BRK: begin
            if (!low) begin
              hcnt <= CNT_W'(1);
              st   <= DELIM;
            end
          end
          DELIM: begin
            if (low) begin
              if (hcnt >= bit_time) begin
                st        <= TLOW;
                cnt       <= LEN_W'(1);
                idx       <= '0;
                dual_q    <= dual_sync;
                cycle_idx <= '0;
                sync_fall <= 1'b1;
              end else begin
                st  <= HUNT;
                run <= RUN_W'(1);
              end
            end else if (hcnt < bit_time) begin
              hcnt <= hcnt + 1'b1;
            end
          end
          TLOW: begin
            if (!low) begin
              sync_rise <= 1'b1;
              low_count <= cnt;
              cnt       <= LEN_W'(1);
              if (idx == last) begin
                sync_done <= 1'b1;
                st        <= HUNT;
                run       <= '0;
              end else begin
                idx <= idx + 4'd1;
                st  <= THIGH;
              end
            end else if (cnt == lim) begin
              st  <= HUNT;
              run <= RUN_W'(cnt) + RUN_W'(1);
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          THIGH: begin
            if (low) begin
              sync_fall <= 1'b1;
              cycle_idx <= idx;
              cnt       <= LEN_W'(1);
              st        <= TLOW;
            end else if (cnt == lim) begin
              st  <= HUNT;
              run <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: st <= HUNT;
        endcase
      end
    end
  end

  a_r2_single_break: assert property (@(posedge clk) disable iff (!rst_n)
    break_det |=> !break_det);

  a_r4_edges_apart: assert property (@(posedge clk) disable iff (!rst_n)
    !(sync_fall && sync_rise));

  a_r5_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    sync_rise |-> (low_count != '0 && low_count <= lim));

  a_r6_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_idx <= 4'd9);

  a_r6_idx_held: assert property (@(posedge clk) disable iff (!rst_n)
    sync_rise |-> $stable(cycle_idx));

  a_r7_done_on_last: assert property (@(posedge clk) disable iff (!rst_n)
    sync_done |-> (sync_rise && cycle_idx == last));

  a_r11_quiet_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !(sync_fall || sync_rise || break_det || sync_done));

endmodule

// File: tb/test_lin_sync_tracker.sv
module test_lin_sync_tracker;
  localparam int CNT_W = 10;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             enable = 1'b0;
  logic             dual_sync = 1'b0;
  logic [CNT_W-1:0] bit_time = CNT_W'(4);
  logic             rx_in = 1'b1;
  logic             break_det, sync_fall, sync_rise, meas_valid, sync_done;
  logic [CNT_W:0]   low_count;
  logic [3:0]       cycle_idx;

  lin_sync_tracker #(.CNT_W(CNT_W), .BREAK_BITS(13)) i_lin_sync_tracker (
    .clk(clk), .rst_n(rst_n), .enable(enable), .dual_sync(dual_sync),
    .bit_time(bit_time), .rx_in(rx_in), .break_det(break_det),
    .sync_fall(sync_fall), .sync_rise(sync_rise), .meas_valid(meas_valid),
    .low_count(low_count), .cycle_idx(cycle_idx), .sync_done(sync_done)
  );

  always #4 clk = ~clk;

  int tests = 0, fails = 0;
  int brk_n, fall_n, rise_n, done_n, dwr_n;
  int lows [0:15];
  int idxs [0:15];
  time tf, t0;

  always @(negedge clk) begin
    if (break_det) brk_n++;
    if (sync_fall) begin
      if (fall_n == 0) tf = $time;
      fall_n++;
    end
    if (meas_valid) begin
      if (rise_n < 16) begin
        lows[rise_n] = int'(low_count);
        idxs[rise_n] = int'(cycle_idx);
      end
      rise_n++;
    end
    if (sync_done) begin
      done_n++;
      if (meas_valid) dwr_n++;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic chk_eq(input string tag, input int act, input int exp);
    check(act == exp, tag, act, exp);
  endtask

  task automatic line(input logic lvl, input int n);
    rx_in = lvl;
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_fsm();
    line(1'b1, 4);
    enable = 1'b0;
    line(1'b1, 2);
    enable = 1'b1;
    line(1'b1, 2);
    brk_n = 0; fall_n = 0; rise_n = 0; done_n = 0; dwr_n = 0;
  endtask

  task automatic send_sync(input int bt, input int nbytes);
    logic [9:0] frame;
    frame = {1'b1, 8'h55, 1'b0};
    for (int b = 0; b < nbytes; b++)
      for (int k = 0; k < 10; k++) line(frame[k], bt);
    line(1'b1, 3 * bt + 4);
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    tests++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    brk_n = 0; fall_n = 0; rise_n = 0; done_n = 0; dwr_n = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!break_det && !sync_fall && !sync_rise && !meas_valid && !sync_done &&
          low_count == 0 && cycle_idx == 0, "R1 in reset", 1, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!break_det && !sync_fall && !sync_rise && !sync_done &&
          low_count == 0 && cycle_idx == 0, "R1 after reset", 1, 0);
    enable = 1'b1;

    for (int bt = 2; bt <= 5; bt++) begin
      bit_time = CNT_W'(bt);
      dual_sync = 1'b0;
      // R2 short low gives no break
      clear_fsm();
      line(1'b0, 13 * bt - 1);
      line(1'b1, 20);
      chk_eq("R2 short low", brk_n, 0);
      // R2 R4 R5 R6 R7 full header
      clear_fsm();
      line(1'b0, 13 * bt);
      line(1'b1, bt);
      send_sync(bt, 1);
      chk_eq("R2 break", brk_n, 1);
      chk_eq("R4 falls", fall_n, 5);
      chk_eq("R4 rises", rise_n, 5);
      chk_eq("R7 done", done_n, 1);
      chk_eq("R7 done with last rise", dwr_n, 1);
      for (int c = 0; c < 5; c++) begin
        chk_eq("R5 low count", lows[c], bt);
        chk_eq("R6 index", idxs[c], c);
      end
      // R3 short delimiter
      clear_fsm();
      line(1'b0, 13 * bt);
      line(1'b1, bt - 1);
      send_sync(bt, 1);
      chk_eq("R3 break seen", brk_n, 1);
      chk_eq("R3 no tracking", fall_n, 0);
      chk_eq("R3 no done", done_n, 0);
    end

    // R8 dual mode
    bit_time = CNT_W'(3);
    dual_sync = 1'b1;
    clear_fsm();
    line(1'b0, 39);
    line(1'b1, 3);
    send_sync(3, 2);
    chk_eq("R8 falls", fall_n, 10);
    chk_eq("R8 rises", rise_n, 10);
    chk_eq("R8 done", done_n, 1);
    chk_eq("R8 done with last rise", dwr_n, 1);
    for (int c = 0; c < 10; c++) begin
      chk_eq("R8 index", idxs[c], c);
      chk_eq("R8 low count", lows[c], 3);
    end
    dual_sync = 1'b0;

    // R5 varied low lengths, R4 latency
    bit_time = CNT_W'(4);
    begin
      int ls [0:4];
      ls[0] = 1; ls[1] = 8; ls[2] = 4; ls[3] = 2; ls[4] = 5;
      clear_fsm();
      line(1'b0, 52);
      line(1'b1, 4);
      t0 = $time;
      for (int c = 0; c < 5; c++) begin
        line(1'b0, ls[c]);
        line(1'b1, 4);
      end
      line(1'b1, 16);
      check(tf - t0 == 24, "R4 latency", int'(tf - t0), 24);
      chk_eq("R5 rises", rise_n, 5);
      for (int c = 0; c < 5; c++) chk_eq("R5 varied low", lows[c], ls[c]);
      chk_eq("R7 done varied", done_n, 1);
    end

    // R9 low abort, no second break at 13*bt-1
    bit_time = CNT_W'(3);
    clear_fsm();
    line(1'b0, 39);
    line(1'b1, 3);
    line(1'b0, 38);
    line(1'b1, 10);
    chk_eq("R9 one fall", fall_n, 1);
    chk_eq("R9 no rise", rise_n, 0);
    chk_eq("R9 no new break", brk_n, 1);
    // R9 abort then full break length
    clear_fsm();
    line(1'b0, 39);
    line(1'b1, 3);
    line(1'b0, 39);
    line(1'b1, 10);
    chk_eq("R9 new break", brk_n, 2);
    chk_eq("R9 no rise full", rise_n, 0);

    // R10 high abort
    clear_fsm();
    line(1'b0, 39);
    line(1'b1, 3);
    line(1'b0, 3);
    line(1'b1, 7);
    line(1'b0, 3);
    line(1'b1, 10);
    chk_eq("R10 aborted falls", fall_n, 1);
    chk_eq("R10 aborted rises", rise_n, 1);
    clear_fsm();
    line(1'b0, 39);
    line(1'b1, 3);
    line(1'b0, 3);
    line(1'b1, 6);
    line(1'b0, 3);
    line(1'b1, 10);
    chk_eq("R10 kept falls", fall_n, 2);
    chk_eq("R10 kept rises", rise_n, 2);

    // R2 stuck low flagged once
    bit_time = CNT_W'(2);
    clear_fsm();
    line(1'b0, 200);
    chk_eq("R2 stuck low", brk_n, 1);

    // R11 disabled
    clear_fsm();
    enable = 1'b0;
    line(1'b0, 26);
    line(1'b1, 2);
    send_sync(2, 1);
    chk_eq("R11 no break", brk_n, 0);
    chk_eq("R11 no falls", fall_n, 0);
    chk_eq("R11 no done", done_n, 0);
    enable = 1'b1;

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule